// File: doc/BRIEF.md
# Infrared Serial Receive Pulse Decoder

This block sits between an infrared receive pin and a UART receiver. The infrared line idles high. A logic 0 bit arrives as a short low-going pulse near the start of its bit period, and a bit period with no pulse stands for a logic 1. The decoder turns this pulse stream into an ordinary non-return-to-zero level that a UART receiver can sample as if it were wired directly to a serial line.

The block runs on the system clock. A one-cycle baud-tick enable, pulsing at sixteen times the bit rate, steps it. The raw input first passes through a flop synchroniser. Falling edges are then detected on every system clock, so a pulse shorter than one tick period is still caught. A local tick counter is re-aligned to each accepted pulse and sets when the output changes: the decoded level appears a fixed number of ticks after the pulse. Once the decoder is locked to a pulse, further edges are accepted only inside a tolerance window around the time the next pulse is expected. Edges outside that window are treated as noise.

An enable input gates the decoder. When the decoder is disabled, its output is held at the idle level and all timing state is discarded.

Top module: `irda_rx_decoder`

## Requirements
- R1: After a synchronous active-high reset, `rxdOut` is 1 and the decoder is unlocked, with no pulse pending.
- R2: One decoded bit lasts 16 baud ticks. The local counter runs 0 to 15 and wraps, so pulses spaced 16 ticks apart keep the decoder locked.
- R3: While unlocked, any falling edge on the infrared input is accepted as a pulse. It locks the decoder and sets the local counter to 0.
- R4: `rxdOut` changes only on the baud tick that takes the counter to 8. An accepted pulse drives `rxdOut` to 0 on the 8th tick after acceptance, and `rxdOut` is still unchanged after the 7th tick.
- R5: While locked, the acceptance window opens on the tick that takes the counter to 12. An edge arriving at count 12 is accepted and re-aligns the counter, so the next update falls 8 ticks after that edge.
- R6: The acceptance window stays open after the counter wraps, until it reaches 8. An edge arriving at count 7 of the following bit period is accepted and re-aligns the counter.
- R7: While locked, a falling edge that arrives with the window closed (counts 1 to 11 after an accepted pulse) is ignored. It neither resets the counter nor makes the decoded bit 0.
- R8: An update at count 8 with no pulse accepted since the previous update sets `rxdOut` to 1 and unlocks the decoder.
- R9: While `enable` is 0, `rxdOut` is 1 from the next clock, the counter is cleared, the decoder is unlocked, and falling edges are ignored.
- R10: The infrared input passes through a two-flop synchroniser. A falling edge is detected and latched on the system clock, so a low pulse lasting three system clocks between two baud ticks is decoded.
- R11: A run of mixed bits sent back to back (a pulse for each 0, none for each 1) appears on `rxdOut` as the same sequence, with each bit valid from the 8th tick of its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Decoder enable; 0 forces idle |
| baudTick | input | 1 | One-cycle enable at 16x the bit rate |
| irRxIn | input | 1 | Raw infrared receive input, active-low pulses |
| rxdOut | output | 1 | Decoded NRZ receive stream for the UART |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, an update at count 8, a window opening at count 12 and two synchroniser stages. It issues one baud tick every eight system clocks, which leaves room for a three-clock pulse to be synchronised and accepted between ticks. With these values, single-tick offsets become reachable: count 11 against count 12 at the early edge of the window, count 7 of the next period at the late edge, and tick 7 against tick 8 for the output lag. The re-alignment after an early or late pulse is observed through when `rxdOut` next returns to 1.

// File: rtl/irda_rx_pkg.sv
package irda_rx_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic clearAll;    // enable low: drop all timing state
    logic acceptEdge;  // an edge is taken as a pulse: zero count, mark bit 0
    logic advance;     // step the local counter by one tick
    logic updateOut;   // counter reaches the update point: load output
  } dpStrobe_t;

endpackage

// File: rtl/irda_rx_datapath.sv
module irda_rx_datapath
  import irda_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int UPDATE_AT     = 8,
  parameter int WIN_OPEN      = 12,
  parameter int SYNC_STAGES   = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      baudTick,
  input  logic      irRxIn,
  input  dpStrobe_t strb,
  output logic      fallEdge,
  output logic      atUpdate,
  output logic      atWinOpen,
  output logic      pulseSeen,
  output logic      rxdOut
);

  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] CNT_PRE_UP = CNT_W'(UPDATE_AT - 1);
  localparam logic [CNT_W-1:0] CNT_PRE_WO = CNT_W'(WIN_OPEN - 1);

  // Input synchroniser chain, idle level is high.
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncQ[0] <= 1'b1;
          else     syncQ[0] <= irRxIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncQ[s] <= 1'b1;
          else     syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prevQ <= 1'b1;
    else     prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign fallEdge = prevQ & ~syncQ[SYNC_STAGES-1];

  // Local tick counter, re-aligned by accepted pulses.
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || strb.clearAll || strb.acceptEdge) begin
      cnt <= '0;
    end else if (strb.advance) begin
      if (cnt == CNT_LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  assign atUpdate  = (cnt == CNT_PRE_UP);
  assign atWinOpen = (cnt == CNT_PRE_WO);

  // Pulse latch: set by an accepted edge, consumed at the update point.
  always_ff @(posedge clk) begin
    if (rst || strb.clearAll) pulseSeen <= 1'b0;
    else if (strb.acceptEdge) pulseSeen <= 1'b1;
    else if (strb.updateOut)  pulseSeen <= 1'b0;
  end

  // Decoded output register.
  always_ff @(posedge clk) begin
    if (rst || strb.clearAll) rxdOut <= 1'b1;
    else if (strb.updateOut)  rxdOut <= ~pulseSeen;
  end

  // Assertions
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_LAST);

  a_r3_accept_zeroes_count: assert property (@(posedge clk) disable iff (rst)
    strb.acceptEdge |=> cnt == '0);

  a_r4_output_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(rxdOut) |-> ($past(baudTick) || $past(strb.clearAll)));

  a_r4_zero_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(rxdOut) |-> $past(pulseSeen));

  a_r9_disable_idles: assert property (@(posedge clk) disable iff (rst)
    strb.clearAll |=> (rxdOut && cnt == '0 && !pulseSeen));

endmodule

// File: rtl/irda_rx_control.sv
module irda_rx_control
  import irda_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      baudTick,
  input  logic      fallEdge,
  input  logic      atUpdate,
  input  logic      atWinOpen,
  input  logic      pulseSeen,
  output dpStrobe_t strb
);

  logic locked;
  logic winOpen;
  logic takeEdge;
  logic stepTick;
  logic doUpdate;

  // An edge is a pulse when unlocked, or locked with the window open.
  assign takeEdge = enable & fallEdge & (~locked | winOpen);
  // An accepted edge wins over a tick in the same clock.
  assign stepTick = enable & locked & baudTick & ~takeEdge;
  assign doUpdate = stepTick & atUpdate;

  always_comb begin
    strb            = '0;
    strb.clearAll   = ~enable;
    strb.acceptEdge = takeEdge;
    strb.advance    = stepTick;
    strb.updateOut  = doUpdate;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable)            locked <= 1'b0;
    else if (takeEdge)             locked <= 1'b1;
    else if (doUpdate && !pulseSeen) locked <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable || takeEdge || doUpdate) winOpen <= 1'b0;
    else if (stepTick && atWinOpen)             winOpen <= 1'b1;
  end

  // Assertions
  a_r7_window_only_when_locked: assert property (@(posedge clk) disable iff (rst)
    winOpen |-> locked);

  a_r8_idle_bit_unlocks: assert property (@(posedge clk) disable iff (rst)
    (doUpdate && !pulseSeen && !takeEdge) |=> !locked);

  a_r3_edge_locks: assert property (@(posedge clk) disable iff (rst)
    (enable && fallEdge && !locked) |=> locked);

  a_r9_disabled_unlocked: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!locked && !winOpen));

endmodule

// File: rtl/irda_rx_decoder.sv
module irda_rx_decoder
  import irda_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int UPDATE_AT     = 8,
  parameter int WIN_OPEN      = 12,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic baudTick,
  input  logic irRxIn,
  output logic rxdOut
);

  dpStrobe_t strb;
  logic      fallEdge;
  logic      atUpdate;
  logic      atWinOpen;
  logic      pulseSeen;

  irda_rx_control u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .baudTick  (baudTick),
    .fallEdge  (fallEdge),
    .atUpdate  (atUpdate),
    .atWinOpen (atWinOpen),
    .pulseSeen (pulseSeen),
    .strb      (strb)
  );

  irda_rx_datapath #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .UPDATE_AT     (UPDATE_AT),
    .WIN_OPEN      (WIN_OPEN),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .baudTick  (baudTick),
    .irRxIn    (irRxIn),
    .strb      (strb),
    .fallEdge  (fallEdge),
    .atUpdate  (atUpdate),
    .atWinOpen (atWinOpen),
    .pulseSeen (pulseSeen),
    .rxdOut    (rxdOut)
  );

endmodule

// File: tb/irda_rx_decoder_tb.sv
module irda_rx_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 8;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst;
  logic enable;
  logic baudTick;
  logic irRxIn;
  logic rxdOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irda_rx_decoder u_dut (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .baudTick (baudTick),
    .irRxIn   (irRxIn),
    .rxdOut   (rxdOut)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: rxdOut=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doTicks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (TICK_GAP - 1) @(negedge clk);
      baudTick = 1'b1;
      @(negedge clk);
      baudTick = 1'b0;
    end
  endtask

  // Three-clock low pulse, placed right after a tick.
  task automatic irPulse();
    @(negedge clk);
    irRxIn = 1'b0;
    repeat (3) @(negedge clk);
    irRxIn = 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; enable = 1'b1; baudTick = 1'b0; irRxIn = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    check("R1 idle after reset", rxdOut, 1'b1);
    doTicks(20);
    check("R1 no activity without pulses", rxdOut, 1'b1);
  endtask

  task automatic testFirstBit();
    doReset();
    irPulse();
    doTicks(7);
    check("R4 unchanged at tick 7", rxdOut, 1'b1);
    doTicks(1);
    check("R3 R10 first pulse decoded at tick 8", rxdOut, 1'b0);
    doTicks(16);
    check("R8 empty period decodes 1", rxdOut, 1'b1);
  endtask

  task automatic testStream();
    bit pattern [10] = '{0, 1, 1, 0, 0, 1, 0, 0, 0, 1};
    doReset();
    foreach (pattern[k]) begin
      if (pattern[k] == 1'b0) irPulse();
      doTicks(8);
      check($sformatf("R11 R2 stream bit %0d", k), rxdOut, pattern[k]);
      doTicks(8);
    end
  endtask

  task automatic testEarly();
    doReset();
    irPulse();
    doTicks(12);
    irPulse();          // arrives at count 12
    doTicks(23);        // 35 ticks after first pulse
    check("R5 early pulse realigns, still 0", rxdOut, 1'b0);
    doTicks(1);
    check("R5 update 8 after early pulse", rxdOut, 1'b1);
  endtask

  task automatic testTooEarly();
    doReset();
    irPulse();
    doTicks(5);
    irPulse();          // count 5, window closed
    doTicks(3);
    check("R7 edge at count 5 leaves counter", rxdOut, 1'b0);
    doTicks(3);
    irPulse();          // count 11, window closed
    doTicks(13);
    check("R7 edge at count 11 not taken as 0", rxdOut, 1'b1);
  endtask

  task automatic testLate();
    doReset();
    irPulse();
    doTicks(23);
    irPulse();          // count 7 of next period
    doTicks(1);
    check("R6 late pulse skips update at 24", rxdOut, 1'b0);
    doTicks(7);
    check("R6 late pulse decoded 0", rxdOut, 1'b0);
    doTicks(16);
    check("R6 idle after late pulse", rxdOut, 1'b1);
  endtask

  task automatic testEnable();
    doReset();
    irPulse();
    doTicks(8);
    check("R9 pre-disable bit 0", rxdOut, 1'b0);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R9 disable forces high", rxdOut, 1'b1);
    irPulse();
    doTicks(8);
    check("R9 edge ignored while disabled", rxdOut, 1'b1);
    @(negedge clk);
    enable = 1'b1;
    doTicks(16);
    check("R9 no stale state after enable", rxdOut, 1'b1);
    irPulse();
    doTicks(7);
    check("R9 counter restarted, tick 7", rxdOut, 1'b1);
    doTicks(1);
    check("R9 counter restarted, tick 8", rxdOut, 1'b0);
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; baudTick = 1'b0; irRxIn = 1'b1;
    testReset();
    testFirstBit();
    testStream();
    testEarly();
    testTooEarly();
    testLate();
    testEnable();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checkCount++;
      failCount++;
      $display("FAIL watchdog: run hung, actual=expired expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

endmodule